// File: doc/BRIEF.md
# Network Controller Interrupt Status Unit

This unit collects the interrupt causes of a packet network controller into one 8-bit status word and drives a single interrupt line. Each status bit is one of two kinds:

- **Latched bits** are set by event pulses or by a level. They hold until software writes a one to that bit position of the acknowledge register.
- **Live bits** follow, inverted, the empty flags of the receive FIFO and the transmit-completion FIFO, and the allocation-failed flag of the buffer allocator.

A mask register selects which status bits reach the interrupt output.

Software uses a single-cycle register port:

- Address `STAT_ADDR` reads the status word. A write to that address is an acknowledge.
- Address `MASK_ADDR` reads and writes the mask.

Acknowledging the transmit-done bit does not change that bit. It asks the completion FIFO to drop its head entry, through a one-cycle pop strobe on the cycle after the write.

Each latched bit is a two-state machine, `LT_CLEAR` and `LT_SET`, with three transitions:

- `CLEAR->SET` when any of its sources is active.
- `SET->CLEAR` on an acknowledge with no source active.
- Every other case holds the current state.

The pop strobe is a two-state machine, `POP_IDLE` and `POP_FIRE`:

- `IDLE->FIRE` on a transmit-done acknowledge while the completion FIFO is non-empty.
- `FIRE->IDLE` on the next cycle, unless another such acknowledge arrives.

Top module: `nic_irq_unit`

## Requirements
- R1: The status word read at `STAT_ADDR` has this layout. Bit 0 is receive. Bit 1 is transmit-done. Bit 2 is transmit-empty. Bit 3 is allocation-done. Bit 4 is receive-overrun. Bit 5 is status-error. Bits 7:6 always read zero.
- R2: A pulse on `rx_overrun_evt` sets bit 4 at the next clock edge. Bit 4 stays set after the pulse ends, until it is acknowledged.
- R3: A write to `STAT_ADDR` with bit 4 set clears bit 4 at the next edge. An acknowledge with bit 4 zero leaves bit 4 set.
- R4: Bit 3 always equals the inverse of `alloc_failed`.
- R5: Bit 2 becomes set at the edge after `txq_empty` is high. It stays set after `txq_empty` falls, until it is acknowledged.
- R6: After an acknowledge of bit 2, the bit reads set if `txq_empty` is still high and reads clear if it is low.
- R7: Bit 1 equals the inverse of `txc_empty`, and bit 0 equals the inverse of `rxq_empty`. An acknowledge has no effect on either bit.
- R8: An acknowledge with bit 1 set while `txc_empty` is low raises `txc_pop` for exactly the following cycle. With `txc_empty` high, no pop is produced.
- R9: A pulse on `link_chg_evt`, `cnt_roll_evt` or `tx_fatal_evt` sets bit 5. Bit 5 holds until an acknowledge with bit 5 set.
- R10: When an event and an acknowledge for the same latched bit arrive in the same cycle, the bit remains set.
- R11: `irq` is high exactly when some status bit and its mask bit are both one. The mask is written and read back at `MASK_ADDR`, and a mask write affects `irq` from the next cycle.
- R12: After reset the mask and all latched bits are zero, `irq` is low and `txc_pop` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data (acknowledge bits or mask) |
| reg_rdata | output | DATA_W | Read data for the current address |
| rx_overrun_evt | input | 1 | Receive overrun caused by a failed allocation |
| txq_empty | input | 1 | Transmit FIFO empty level |
| txc_empty | input | 1 | Transmit-completion FIFO empty level |
| rxq_empty | input | 1 | Receive FIFO empty level |
| alloc_failed | input | 1 | Allocation-failed flag from the buffer allocator |
| link_chg_evt | input | 1 | Link test transition pulse |
| cnt_roll_evt | input | 1 | Statistics counter rollover pulse |
| tx_fatal_evt | input | 1 | Fatal transmit error pulse |
| txc_pop | output | 1 | One-cycle pop request to the completion FIFO |
| irq | output | 1 | Masked interrupt output |

## Verification
The bench builds the unit with its default parameters: an 8-bit data path, a 1-bit address, status at address 0 and mask at address 1. This covers every implemented status bit and both reserved bits.

The scenarios exercise these cases:
- Each latched bit through set, hold and clear.
- A same-cycle clash between an event and an acknowledge.
- Acknowledge attempts on the live bits.
- The pop strobe with the completion FIFO both full and empty.
- Masking with zero, single-bit and full masks.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;

    localparam int STAT_W    = 8;
    localparam int B_RCV     = 0;
    localparam int B_TXDONE  = 1;
    localparam int B_TXEMPTY = 2;
    localparam int B_ALLOC   = 3;
    localparam int B_OVRN    = 4;
    localparam int B_STERR   = 5;
    localparam int N_USED    = 6;

    typedef enum logic {
        LT_CLEAR = 1'b0,
        LT_SET   = 1'b1
    } latch_state_e;

    typedef enum logic {
        POP_IDLE = 1'b0,
        POP_FIRE = 1'b1
    } pop_state_e;

endpackage

// File: rtl/nic_irq_latch.sv
module nic_irq_latch
    import nic_irq_pkg::*;
#(
    parameter int N_SRC = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src,
    input  logic             ack,
    output logic             flag
);

    latch_state_e state_q, state_d;
    logic         any_src;

    assign any_src = |src;

    // next-state logic: the event has priority over the acknowledge
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LT_CLEAR: if (any_src) state_d = LT_SET;
            LT_SET:   if (ack && !any_src) state_d = LT_CLEAR;
            default:  state_d = LT_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LT_CLEAR;
        else        state_q <= state_d;
    end

    // output process
    always_comb begin
        flag = 1'b0;
        unique case (state_q)
            LT_CLEAR: flag = 1'b0;
            LT_SET:   flag = 1'b1;
            default:  flag = 1'b0;
        endcase
    end

    // R10: a source present in a cycle always leaves the bit set afterwards
    p_evt_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        any_src |=> flag);

    // R2 / R9: a set bit with no acknowledge keeps its value
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !ack) |=> flag);

    // R3: an acknowledge without a source clears the bit
    p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !any_src) |=> !flag);

endmodule

// File: rtl/nic_irq_regs.sv
module nic_irq_regs
    import nic_irq_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 1,
    parameter int STAT_ADDR = 0,
    parameter int MASK_ADDR = 1,
    parameter int POP_BIT   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] status,
    input  logic              pop_allowed,
    output logic [DATA_W-1:0] ack_vec,
    output logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] rdata,
    output logic              pop
);

    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_ADDR);

    logic       stat_wr, mask_wr, pop_req;
    pop_state_e pop_q, pop_d;

    assign stat_wr = wr_en && (addr == A_STAT);
    assign mask_wr = wr_en && (addr == A_MASK);
    assign ack_vec = stat_wr ? wdata : '0;
    assign pop_req = stat_wr && wdata[POP_BIT] && pop_allowed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask <= '0;
        else if (mask_wr) mask <= wdata;
    end

    always_comb begin
        if (addr == A_MASK) rdata = mask;
        else if (addr == A_STAT) rdata = status;
        else rdata = '0;
    end

    // pop strobe state machine
    always_comb begin
        pop_d = pop_q;
        unique case (pop_q)
            POP_IDLE: if (pop_req)  pop_d = POP_FIRE;
            POP_FIRE: if (!pop_req) pop_d = POP_IDLE;
            default:  pop_d = POP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pop_q <= POP_IDLE;
        else        pop_q <= pop_d;
    end

    always_comb begin
        pop = 1'b0;
        unique case (pop_q)
            POP_IDLE: pop = 1'b0;
            POP_FIRE: pop = 1'b1;
            default:  pop = 1'b0;
        endcase
    end

    // R8: each pop follows a qualifying acknowledge one cycle earlier
    p_pop_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> $past(stat_wr && wdata[POP_BIT] && pop_allowed));

    // R8: a qualifying acknowledge always produces a pop
    p_pop_issue_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req |=> pop);

    // R11: a mask write is visible on the next cycle
    p_mask_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> (mask == $past(wdata)));

    // R11: without a mask write the mask is stable
    p_mask_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_wr |=> $stable(mask));

endmodule

// File: rtl/nic_irq_unit.sv
module nic_irq_unit
    import nic_irq_pkg::*;
#(
    parameter int DATA_W    = STAT_W,
    parameter int ADDR_W    = 1,
    parameter int STAT_ADDR = 0,
    parameter int MASK_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              rx_overrun_evt,
    input  logic              txq_empty,
    input  logic              txc_empty,
    input  logic              rxq_empty,
    input  logic              alloc_failed,
    input  logic              link_chg_evt,
    input  logic              cnt_roll_evt,
    input  logic              tx_fatal_evt,
    output logic              txc_pop,
    output logic              irq
);

    logic [DATA_W-1:0] status;
    logic [DATA_W-1:0] ack_vec;
    logic [DATA_W-1:0] mask;
    logic              ovrn_flag, txe_flag, sterr_flag;
    logic              unused_ack;

    nic_irq_latch #(.N_SRC(1)) u_ovrn (
        .clk(clk), .rst_n(rst_n),
        .src(rx_overrun_evt), .ack(ack_vec[B_OVRN]), .flag(ovrn_flag)
    );

    nic_irq_latch #(.N_SRC(1)) u_txe (
        .clk(clk), .rst_n(rst_n),
        .src(txq_empty), .ack(ack_vec[B_TXEMPTY]), .flag(txe_flag)
    );

    nic_irq_latch #(.N_SRC(3)) u_sterr (
        .clk(clk), .rst_n(rst_n),
        .src({link_chg_evt, cnt_roll_evt, tx_fatal_evt}),
        .ack(ack_vec[B_STERR]), .flag(sterr_flag)
    );

    always_comb begin
        status            = '0;
        status[B_RCV]     = !rxq_empty;
        status[B_TXDONE]  = !txc_empty;
        status[B_TXEMPTY] = txe_flag;
        status[B_ALLOC]   = !alloc_failed;
        status[B_OVRN]    = ovrn_flag;
        status[B_STERR]   = sterr_flag;
    end

    nic_irq_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .STAT_ADDR(STAT_ADDR), .MASK_ADDR(MASK_ADDR), .POP_BIT(B_TXDONE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .status(status), .pop_allowed(!txc_empty),
        .ack_vec(ack_vec), .mask(mask), .rdata(reg_rdata), .pop(txc_pop)
    );

    // acknowledge bits that have no latch behind them
    generate
        if (DATA_W > N_USED) begin : g_spare
            assign unused_ack = ^{ack_vec[DATA_W-1:N_USED], ack_vec[B_RCV],
                                  ack_vec[B_TXDONE], ack_vec[B_ALLOC]};
        end else begin : g_nospare
            assign unused_ack = ^{ack_vec[B_RCV], ack_vec[B_TXDONE], ack_vec[B_ALLOC]};
        end
    endgenerate

    assign irq = |(status & mask);

    // R11: an all-zero mask keeps the line low
    p_mask_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);

    // R2: an overrun pulse is visible in the status word next cycle
    p_ovrn_seen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun_evt |=> reg_rdata[B_OVRN] || (reg_addr != ADDR_W'(STAT_ADDR)));

    // R5: a transmit FIFO that stays empty keeps bit 2 set
    p_txe_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        txq_empty |=> txe_flag);

    // R12: no pop right after reset release
    p_pop_reset_r12: assert property (@(posedge clk)
        !rst_n |=> !txc_pop);

endmodule

// File: tb/nic_irq_unit_bench.sv
module nic_irq_unit_bench;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [0:0]    reg_addr = 1'b0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic rx_overrun_evt = 1'b0, txq_empty = 1'b0, txc_empty = 1'b1, rxq_empty = 1'b1;
    logic alloc_failed = 1'b1, link_chg_evt = 1'b0, cnt_roll_evt = 1'b0, tx_fatal_evt = 1'b0;
    logic txc_pop, irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    typedef struct {
        int          kind;   // 0 rdata, 1 irq, 2 pop
        logic [7:0]  exp;
        string       req;
    } item_t;

    item_t sb[$];

    always #2 clk = ~clk;

    nic_irq_unit u_nic_irq_unit (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_overrun_evt(rx_overrun_evt), .txq_empty(txq_empty), .txc_empty(txc_empty),
        .rxq_empty(rxq_empty), .alloc_failed(alloc_failed), .link_chg_evt(link_chg_evt),
        .cnt_roll_evt(cnt_roll_evt), .tx_fatal_evt(tx_fatal_evt),
        .txc_pop(txc_pop), .irq(irq)
    );

    // monitor: pops expected items and compares away from the rising edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = sb.pop_front();
            act = (it.kind == 0) ? reg_rdata : (it.kind == 1) ? {7'd0, irq} : {7'd0, txc_pop};
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.req, it.kind, act, it.exp);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0; reg_wdata = '0; reg_addr = 1'b0;
    endtask

    task automatic expect_item(input int kind, input logic a, input logic [7:0] e, input string req);
        item_t it;
        reg_addr = a;
        it.kind = kind; it.exp = e; it.req = req;
        sb.push_back(it);
        @(negedge clk);
        #1;
        reg_addr = 1'b0;
    endtask

    task automatic pulse(ref logic s);
        s = 1'b1;
        tick();
        s = 1'b0;
    endtask

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        // R12 reset state
        expect_item(0, 1'b0, 8'h00, "R12 status");
        expect_item(0, 1'b1, 8'h00, "R12 mask");
        expect_item(1, 1'b0, 8'h00, "R12 irq");
        expect_item(2, 1'b0, 8'h00, "R12 pop");

        // R4 allocation-done is inverse of failed
        alloc_failed = 1'b0;
        expect_item(0, 1'b0, 8'h08, "R4 alloc done");
        alloc_failed = 1'b1;
        expect_item(0, 1'b0, 8'h00, "R4 alloc failed");

        // R2 / R3 overrun latch
        pulse(rx_overrun_evt);
        expect_item(0, 1'b0, 8'h10, "R2 overrun set");
        tick(); tick();
        expect_item(0, 1'b0, 8'h10, "R2 overrun held");
        wr(1'b0, 8'hEF);
        expect_item(0, 1'b0, 8'h10, "R3 ack other bits");
        wr(1'b0, 8'h10);
        expect_item(0, 1'b0, 8'h00, "R3 ack clears");

        // R5 / R6 transmit-empty latch
        txq_empty = 1'b1;
        tick();
        expect_item(0, 1'b0, 8'h04, "R5 tx empty set");
        txq_empty = 1'b0;
        tick();
        expect_item(0, 1'b0, 8'h04, "R5 tx empty held");
        wr(1'b0, 8'h04);
        expect_item(0, 1'b0, 8'h00, "R6 ack not empty");
        txq_empty = 1'b1;
        tick();
        wr(1'b0, 8'h04);
        expect_item(0, 1'b0, 8'h04, "R6 ack still empty");
        txq_empty = 1'b0;
        wr(1'b0, 8'h04);
        expect_item(0, 1'b0, 8'h00, "R6 cleared");

        // R7 live bits ignore acknowledge
        rxq_empty = 1'b0; txc_empty = 1'b0;
        expect_item(0, 1'b0, 8'h03, "R7 live bits");
        wr(1'b0, 8'h01);
        expect_item(0, 1'b0, 8'h03, "R7 ack no effect");
        rxq_empty = 1'b1;
        expect_item(0, 1'b0, 8'h02, "R7 rcv follows");

        // R8 pop strobe
        wr(1'b0, 8'h02);
        expect_item(2, 1'b0, 8'h01, "R8 pop high");
        expect_item(0, 1'b0, 8'h02, "R7 txdone unchanged");
        tick();
        expect_item(2, 1'b0, 8'h00, "R8 pop one cycle");
        txc_empty = 1'b1;
        wr(1'b0, 8'h02);
        expect_item(2, 1'b0, 8'h00, "R8 no pop when empty");

        // R9 status-error sources
        pulse(link_chg_evt);
        expect_item(0, 1'b0, 8'h20, "R9 link");
        wr(1'b0, 8'h20);
        expect_item(0, 1'b0, 8'h00, "R9 cleared");
        pulse(cnt_roll_evt);
        expect_item(0, 1'b0, 8'h20, "R9 rollover");
        wr(1'b0, 8'h20);
        pulse(tx_fatal_evt);
        expect_item(0, 1'b0, 8'h20, "R9 fatal");

        // R10 event and acknowledge in one cycle
        reg_addr = 1'b0; reg_wdata = 8'h30; reg_wr = 1'b1; rx_overrun_evt = 1'b1;
        tick();
        reg_wr = 1'b0; rx_overrun_evt = 1'b0;
        expect_item(0, 1'b0, 8'h10, "R10 event wins");

        // R11 masking
        expect_item(1, 1'b0, 8'h00, "R11 masked off");
        wr(1'b1, 8'h20);
        expect_item(0, 1'b1, 8'h20, "R11 mask readback");
        expect_item(1, 1'b0, 8'h00, "R11 other bit masked");
        wr(1'b1, 8'h10);
        expect_item(1, 1'b0, 8'h01, "R11 irq on");
        wr(1'b0, 8'h10);
        expect_item(1, 1'b0, 8'h00, "R11 irq off after ack");
        alloc_failed = 1'b0;
        wr(1'b1, 8'hFF);
        expect_item(1, 1'b0, 8'h01, "R11 full mask");
        expect_item(0, 1'b0, 8'h08, "R1 reserved zero");
        alloc_failed = 1'b1;
        expect_item(1, 1'b0, 8'h00, "R11 live drop");

        tick();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule